// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit sits on the address path between a processor and physical memory. Each virtual address it receives is cut into a page index (upper bits) and an in-page offset (lower bits). The page index is looked up in the translation table that belongs to the process currently selected. When the entry says the page is resident, the unit forwards a memory cycle whose physical address joins the stored frame number to the untouched offset. When the page is not resident, the unit raises a fault line and forwards no memory cycle.

Each process has its own table, so one virtual address can land on different frames for different processes. System software fills table entries and picks the current process through a small configuration write port. A configuration write made while the processor is in user mode changes nothing and raises a one-cycle privilege-violation pulse. Translation is purely combinational inside the access cycle, so a hit adds no cycle to the memory access. Defaults: 16-bit virtual address, 2 KB pages (5-bit page index, 11-bit offset), 4 processes, 8-bit frame number, 19-bit physical address.

Top module: `atu_xlate`

## Requirements
- R1: In the same cycle as an access (`acc_valid`=1) to a resident page, `mem_valid` is 1, `mem_fault` is 0 and `mem_paddr[18:11]` equals the frame stored for that page of the current process.
- R2: On a translated access, `mem_paddr[10:0]` equals `acc_vaddr[10:0]`; the page index is `acc_vaddr[15:11]`.
- R3: The table used is the one of the current process, so the same virtual address maps to different frames after the current process changes.
- R4: An access to a page whose present bit is 0 drives `mem_fault`=1, `mem_valid`=0 and `mem_paddr`=0 in the same cycle.
- R5: With `acc_valid`=0, `mem_valid`, `mem_fault` and `mem_paddr` are all 0.
- R6: After reset every present bit is 0 and the current process is 0, so every access faults until entries are loaded.
- R7: A configuration write with `sys_mode`=0 changes neither any table entry nor the current process.
- R8: `priv_viol` is 1 for exactly the cycle after a clock edge at which `cfg_we`=1 and `sys_mode`=0, and 0 otherwise (never after a system-mode write).
- R9: A system-mode write with `cfg_op`=0 stores `cfg_present` and `cfg_frame` for page `cfg_page` of process `cfg_proc`, visible from the next cycle, and leaves entries of other processes unchanged.
- R10: A system-mode write with `cfg_op`=1 makes `cfg_proc` the current process from the next cycle; writing an entry with `cfg_present`=0 makes that page fault again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Processor access in this cycle |
| acc_vaddr | input | 16 | Virtual address of the access |
| mem_valid | output | 1 | Memory cycle forwarded |
| mem_paddr | output | 19 | Physical address (frame, offset) |
| mem_fault | output | 1 | Access to a non-resident page |
| sys_mode | input | 1 | 1 when the processor runs in system mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 1 | 0 = write table entry, 1 = select current process |
| cfg_proc | input | 2 | Process of the entry, or new current process |
| cfg_page | input | 5 | Page index of the entry |
| cfg_present | input | 1 | Present bit to store |
| cfg_frame | input | 8 | Frame number to store |
| priv_viol | output | 1 | One-cycle pulse after a user-mode configuration write |

## Verification
The assertions assume the inputs are settled known values at each rising edge and that reset is held for at least one edge before checking begins; the offset and exclusivity properties also assume `acc_vaddr` is stable while `acc_valid` is high. The bench meets this by changing every input only on falling edges and by keeping configuration writes and accesses in separate cycles, so each expected translation comes from a reference table that is settled when the access is driven. User-mode writes are issued with values that differ from the stored ones, so an ignored write becomes visible through a later translation.

// File: rtl/atu_pkg.sv
package atu_pkg;
  // Configuration operation selector carried on cfg_op
  typedef enum logic {
    CFG_ENTRY = 1'b0,
    CFG_PID   = 1'b1
  } cfg_op_e;
endpackage

// File: rtl/atu_table.sv
// Per-process page tables held in flops; one entry per (process, page).
module atu_table #(
  parameter int PROC_W  = 2,
  parameter int PAGE_W  = 5,
  parameter int FRAME_W = 8,
  localparam int IDX_W  = PROC_W + PAGE_W,
  localparam int NENT   = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PROC_W-1:0]  wr_proc,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic               wr_present,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [PROC_W-1:0]  rd_proc,
  input  logic [PAGE_W-1:0]  rd_page,
  output logic               rd_present,
  output logic [FRAME_W-1:0] rd_frame
);
  function automatic logic [IDX_W-1:0] slot(input logic [PROC_W-1:0] p,
                                             input logic [PAGE_W-1:0] g);
    return {p, g};
  endfunction

  logic               pres_q  [NENT];
  logic [FRAME_W-1:0] frame_q [NENT];

  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  assign wr_idx = slot(wr_proc, wr_page);
  assign rd_idx = slot(rd_proc, rd_page);

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pres_q[e]  <= 1'b0;
        frame_q[e] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(e)) begin
        pres_q[e]  <= wr_present;
        frame_q[e] <= wr_frame;
      end
    end
  end

  assign rd_present = pres_q[rd_idx];
  assign rd_frame   = frame_q[rd_idx];
endmodule

// File: rtl/atu_gate.sv
// Privilege gate for configuration writes; owns the current-process register.
module atu_gate #(
  parameter int PROC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_mode,
  input  logic              cfg_we,
  input  atu_pkg::cfg_op_e  cfg_op,
  input  logic [PROC_W-1:0] cfg_proc,
  output logic              entry_we,
  output logic [PROC_W-1:0] cur_pid,
  output logic              priv_viol
);
  import atu_pkg::*;

  logic allowed;
  logic refused;
  assign allowed  = cfg_we && sys_mode;
  assign refused  = cfg_we && !sys_mode;
  assign entry_we = allowed && (cfg_op == CFG_ENTRY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_pid   <= '0;
      priv_viol <= 1'b0;
    end else begin
      priv_viol <= refused;
      if (allowed && cfg_op == CFG_PID) cur_pid <= cfg_proc;
    end
  end
endmodule

// File: rtl/atu_xlate.sv
// Paged address translation: virtual page -> frame for the current process.
module atu_xlate #(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 11,
  parameter int NPROC   = 4,
  parameter int FRAME_W = 8,
  localparam int PAGE_W = VA_W - OFF_W,
  localparam int PROC_W = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [VA_W-1:0]    acc_vaddr,
  output logic               mem_valid,
  output logic [PA_W-1:0]    mem_paddr,
  output logic               mem_fault,
  input  logic               sys_mode,
  input  logic               cfg_we,
  input  logic               cfg_op,
  input  logic [PROC_W-1:0]  cfg_proc,
  input  logic [PAGE_W-1:0]  cfg_page,
  input  logic               cfg_present,
  input  logic [FRAME_W-1:0] cfg_frame,
  output logic               priv_viol
);
  import atu_pkg::*;

  function automatic logic [PAGE_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [FRAME_W-1:0] f,
                                              input logic [OFF_W-1:0] o);
    return {f, o};
  endfunction

  // Named internal events for the checker
  logic [PAGE_W-1:0]  va_page;
  logic [OFF_W-1:0]   va_off;
  logic [PROC_W-1:0]  cur_pid;
  logic               entry_we;
  logic               tab_present;
  logic [FRAME_W-1:0] tab_frame;
  logic               hit;
  logic               miss;

  assign va_page = page_of(acc_vaddr);
  assign va_off  = off_of(acc_vaddr);

  atu_gate #(.PROC_W(PROC_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_mode  (sys_mode),
    .cfg_we    (cfg_we),
    .cfg_op    (cfg_op_e'(cfg_op)),
    .cfg_proc  (cfg_proc),
    .entry_we  (entry_we),
    .cur_pid   (cur_pid),
    .priv_viol (priv_viol)
  );

  atu_table #(.PROC_W(PROC_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_tab (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (entry_we),
    .wr_proc    (cfg_proc),
    .wr_page    (cfg_page),
    .wr_present (cfg_present),
    .wr_frame   (cfg_frame),
    .rd_proc    (cur_pid),
    .rd_page    (va_page),
    .rd_present (tab_present),
    .rd_frame   (tab_frame)
  );

  assign hit  = acc_valid && tab_present;
  assign miss = acc_valid && !tab_present;

  assign mem_valid = hit;
  assign mem_fault = miss;
  assign mem_paddr = hit ? join_pa(tab_frame, va_off) : '0;
endmodule

// File: rtl/atu_chk.sv
// Checker for atu_xlate, attached with bind.
module atu_chk #(
  parameter int VA_W   = 16,
  parameter int OFF_W  = 11,
  parameter int PROC_W = 2,
  parameter int PA_W   = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [VA_W-1:0]   acc_vaddr,
  input logic              mem_valid,
  input logic [PA_W-1:0]   mem_paddr,
  input logic              mem_fault,
  input logic              sys_mode,
  input logic              cfg_we,
  input logic              priv_viol,
  input logic [PROC_W-1:0] cur_pid
);
  // R2
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_paddr[OFF_W-1:0] == acc_vaddr[OFF_W-1:0]);

  // R4
  fault_or_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (mem_valid != mem_fault));

  // R4
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fault |-> (!mem_valid && mem_paddr == '0));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!mem_valid && !mem_fault && mem_paddr == '0));

  // R7
  user_pid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !sys_mode) |=> cur_pid == $past(cur_pid));

  // R8
  viol_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !sys_mode) |=> priv_viol);

  // R8
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |-> $past(cfg_we && !sys_mode));
endmodule

bind atu_xlate atu_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PROC_W(PROC_W), .PA_W(PA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_vaddr (acc_vaddr),
  .mem_valid (mem_valid),
  .mem_paddr (mem_paddr),
  .mem_fault (mem_fault),
  .sys_mode  (sys_mode),
  .cfg_we    (cfg_we),
  .priv_viol (priv_viol),
  .cur_pid   (cur_pid)
);

// File: tb/atu_xlate_test.sv
`timescale 1ns/1ps
module atu_xlate_test;
  localparam int VA_W = 16, OFF_W = 11, FRAME_W = 8, PA_W = 19;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_valid = 1'b0;
  logic [VA_W-1:0]   acc_vaddr = '0;
  logic              mem_valid;
  logic [PA_W-1:0]   mem_paddr;
  logic              mem_fault;
  logic              sys_mode = 1'b0;
  logic              cfg_we = 1'b0;
  logic              cfg_op = 1'b0;
  logic [1:0]        cfg_proc = '0;
  logic [4:0]        cfg_page = '0;
  logic              cfg_present = 1'b0;
  logic [FRAME_W-1:0] cfg_frame = '0;
  logic              priv_viol;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  atu_xlate uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
    .mem_valid(mem_valid), .mem_paddr(mem_paddr), .mem_fault(mem_fault),
    .sys_mode(sys_mode), .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_proc(cfg_proc),
    .cfg_page(cfg_page), .cfg_present(cfg_present), .cfg_frame(cfg_frame),
    .priv_viol(priv_viol)
  );

  // Reference tables, written from the requirements
  logic               ref_pres  [4][32];
  logic [FRAME_W-1:0] ref_frame [4][32];
  logic [1:0]         ref_pid;

  typedef struct {
    logic            v;
    logic            f;
    logic [PA_W-1:0] pa;
    string           tag;
  } exp_t;
  exp_t sb[$];
  event mon_ev;

  task automatic check1(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      @(mon_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        tests++;
        if (mem_valid !== e.v || mem_fault !== e.f || mem_paddr !== e.pa) begin
          fails++;
          $display("FAIL %s actual v=%b f=%b pa=%h expected v=%b f=%b pa=%h",
                   e.tag, mem_valid, mem_fault, mem_paddr, e.v, e.f, e.pa);
        end
      end
    end
  end

  // Driver: one access, expectation from the reference tables
  task automatic access(logic [VA_W-1:0] va, string tag);
    exp_t e;
    logic [4:0] pg;
    @(negedge clk);
    acc_valid = 1'b1;
    acc_vaddr = va;
    pg = va[15:11];
    e.tag = tag;
    if (ref_pres[ref_pid][pg]) begin
      e.v = 1'b1; e.f = 1'b0;
      e.pa = {ref_frame[ref_pid][pg], va[10:0]};
    end else begin
      e.v = 1'b0; e.f = 1'b1; e.pa = '0;
    end
    sb.push_back(e);
    #1 -> mon_ev;
  endtask

  task automatic idle(string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_vaddr = 16'hBEEF;
    e.v = 1'b0; e.f = 1'b0; e.pa = '0; e.tag = tag;
    sb.push_back(e);
    #1 -> mon_ev;
  endtask

  // Configuration write; also checks the privilege pulse (R8)
  task automatic cfg(logic sys, logic op, logic [1:0] pr, logic [4:0] pg,
                     logic pres, logic [FRAME_W-1:0] fr);
    @(negedge clk);
    acc_valid = 1'b0;
    sys_mode = sys; cfg_we = 1'b1; cfg_op = op; cfg_proc = pr;
    cfg_page = pg; cfg_present = pres; cfg_frame = fr;
    @(negedge clk);
    cfg_we = 1'b0; sys_mode = 1'b0;
    #1 check1("R8 pulse after write", 32'(priv_viol), 32'(!sys));
    @(negedge clk);
    #1 check1("R8 pulse lasts one cycle", 32'(priv_viol), 32'd0);
    if (sys) begin
      if (op) ref_pid = pr;
      else begin
        ref_pres[pr][pg]  = pres;
        ref_frame[pr][pg] = fr;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int g = 0; g < 32; g++) begin
        ref_pres[p][g] = 1'b0;
        ref_frame[p][g] = '0;
      end
    ref_pid = 2'd0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check1("R6 reset priv_viol", 32'(priv_viol), 32'd0);
    idle("R5 idle after reset");
    access(16'h1234, "R6 fault after reset");
    access(16'hFFFF, "R6 fault top page after reset");

    // R9 / R1 / R2: load proc0 page 3
    cfg(1'b1, 1'b0, 2'd0, 5'd3, 1'b1, 8'hA5);
    access({5'd3, 11'h7FF}, "R1 hit max offset");
    access({5'd3, 11'h000}, "R2 hit zero offset");
    access({5'd3, 11'h2A5}, "R2 hit mixed offset");

    // R9: other process's entry does not disturb proc0
    cfg(1'b1, 1'b0, 2'd1, 5'd3, 1'b1, 8'h3C);
    access({5'd3, 11'h155}, "R9 proc0 untouched");

    // R10 / R3: switch process
    cfg(1'b1, 1'b1, 2'd1, 5'd0, 1'b0, 8'h00);
    access({5'd3, 11'h155}, "R3 same va new frame");

    // R7: user-mode writes ignored
    cfg(1'b0, 1'b0, 2'd1, 5'd3, 1'b1, 8'hFF);
    access({5'd3, 11'h001}, "R7 user entry write ignored");
    cfg(1'b0, 1'b1, 2'd0, 5'd0, 1'b0, 8'h00);
    access({5'd3, 11'h001}, "R7 user pid write ignored");
    cfg(1'b0, 1'b0, 2'd1, 5'd31, 1'b1, 8'h77);
    access(16'hFFFF, "R7 user present write ignored R4 fault");

    // R10: clearing present bit faults again
    cfg(1'b1, 1'b0, 2'd1, 5'd3, 1'b0, 8'h3C);
    access({5'd3, 11'h001}, "R10 cleared page faults");
    idle("R5 no access no fault");

    // Fill proc2 fully and sweep all pages
    for (int g = 0; g < 32; g++)
      cfg(1'b1, 1'b0, 2'd2, 5'(g), (g % 5) != 4, 8'((g * 7 + 1) & 8'hFF));
    cfg(1'b1, 1'b1, 2'd2, 5'd0, 1'b0, 8'h00);
    for (int g = 0; g < 32; g++)
      access({5'(g), 11'((g * 37) & 11'h7FF)}, "R1 R4 sweep proc2");

    // back to proc0: R3 isolation again
    cfg(1'b1, 1'b1, 2'd0, 5'd0, 1'b0, 8'h00);
    access({5'd3, 11'h3FF}, "R3 back to proc0");
    access({5'd4, 11'h3FF}, "R4 proc0 unloaded page");
    idle("R5 final idle");

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule